// File: doc/BRIEF.md
# Two-Wire Slave Message Framer

This block sits on top of a two-wire (I2C) slave byte engine. It receives one status event per byte: an interrupt flag, an end-of-transfer flag, a "byte received" flag, a read-direction flag, and the byte itself. From these events it builds framed messages. When the master writes, the block stores the bytes into an RX slot that an external allocator grants. It then checks the length of the finished message against the length encoded in its header, and either queues the message or discards it. When the master reads, the block returns the head message of an external TX queue one byte at a time. If that queue is empty, it returns a fixed three-byte filler message instead.

A request line, active low, tells the master that the host wants to talk. An upstream agent lowers it with a kick pulse. The framer raises it once the first byte of a read has been returned, and lowers it again when a read ends too early. The event input uses valid/ready, but `evt_ready` is tied high: the byte engine paces the bus, so the framer takes one event every cycle and never applies back-pressure. Every output is registered and reacts one cycle after the event that caused it. The `tx_valid`/`tx_byte` stream has no ready, so the byte engine must capture the byte in the cycle it is presented.

Top module: `i2c_msg_framer`

## Requirements
- R1: An accepted event whose irq flag is clear has no effect. It produces no output pulse, and the framing state, byte position and stored header are unchanged.
- R2: An event with irq and received set, and read-direction and end clear, is an address byte. It moves the framer to the command phase from any state. If the byte differs from `cfg_addr`, it pulses `addr_mismatch`, but framing continues.
- R3: In the command phase, an irq-only event with `rx_slot_avail` high pulses `rx_take` and writes the byte at index 0. With no slot available, the framer returns to idle.
- R4: After the command byte, an irq-only event writes index 1 and enters the receive phase. Each further irq-only byte is written at the next index.
- R5: After the command byte, an event with irq, read-direction and received set starts a master read. It is legal only when the command byte was 0x01. A legal read pulses `rx_drop` to release the slot and returns byte 0 of the selected TX message. An illegal read returns 0xFF and goes idle.
- R6: If `txq_nonempty` is low when a read starts, the bytes returned are 0x02, 0x07, 0x02. Completing that filler does not pulse `tx_pop`.
- R7: Each further read event returns the next TX byte. When end-of-transfer arrives after all `txq_len` bytes have been sent, the framer pulses `tx_pop` (real message only) and goes idle. An earlier end-of-transfer restarts the message at byte 0 and lowers `req_n`. A read past the last byte returns 0xFF and goes idle.
- R8: The expected RX length comes from the header byte h (index 0) and the count byte c (index 1). When h[7]=0 or h[6:5]=0, the length is c+2. When h[6:5]=1 it is 2, when h[6:5]=2 it is 3, and h[6:5]=3 never matches.
- R9: In the receive phase, end-of-transfer with read-direction clear closes the message. If the byte count differs from the expected length, the framer pulses `rx_drop`. Otherwise it pulses `rx_done`, and also pulses `xfer_done` when h[7]=0.
- R10: In the command, first-byte, send and receive phases, any flag combination not listed above returns the framer to idle.
- R11: In the receive phase, bytes at index MSG_MAX and beyond are not written. Each such byte pulses `rx_overflow`, and the framer stays in the receive phase.
- R12: `req_n` resets high. A `tx_kick` pulse drives it low. A legal read start drives it high, and this wins over a kick in the same cycle.
- R13: Every irq event with read-direction set and end clear produces exactly one `tx_valid` beat one cycle later. Its byte is 0xFF unless R5, R6 or R7 supplies a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Expected address byte |
| evt_valid | input | 1 | Byte event valid |
| evt_ready | output | 1 | Always high |
| evt_irq | input | 1 | Interrupt flag of the event |
| evt_end | input | 1 | End-of-transfer flag |
| evt_rcvd | input | 1 | Byte-received flag |
| evt_rnw | input | 1 | Read-direction flag |
| evt_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Byte to return to the master is valid |
| tx_byte | output | 8 | Byte to return |
| rx_slot_avail | input | 1 | Allocator has a free RX slot |
| rx_take | output | 1 | Claim an RX slot |
| rx_wr_valid | output | 1 | RX byte write strobe |
| rx_wr_idx | output | PW | RX byte index |
| rx_wr_data | output | 8 | RX byte data |
| rx_done | output | 1 | RX message complete and queued |
| rx_drop | output | 1 | RX slot released |
| xfer_done | output | 1 | Response (non-event) message received |
| txq_nonempty | input | 1 | TX queue holds a message |
| txq_len | input | PW | Byte length of the head TX message |
| tx_rd_idx | output | PW | Byte index read from the head TX message |
| tx_rd_data | input | 8 | Head TX message byte at `tx_rd_idx` (combinational) |
| tx_pop | output | 1 | Head TX message fully sent |
| tx_kick | input | 1 | Request to lower the request line |
| req_n | output | 1 | Request line, active low |
| addr_mismatch | output | 1 | Address byte differed from `cfg_addr` |
| rx_overflow | output | 1 | RX byte dropped beyond MSG_MAX |

## Verification
A wrong framing state shows up within one event. The next byte is written at the wrong `rx_wr_idx`, or a read returns 0xFF instead of data, or `rx_take`/`rx_drop` appear when they should not. A corrupted byte position or latched length surfaces at the latest at the closing end-of-transfer, as a `rx_done`/`rx_drop` swap or a missing `tx_pop`. A stale filler or header choice shows in the very next `tx_byte`, or in `xfer_done`. The reference model predicts every registered output for the cycle after each event and compares all of them on every clock.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_FIRST = 3'd2,
    ST_SEND  = 3'd3,
    ST_RECV  = 3'd4
  } fr_state_e;

  typedef enum logic [1:0] {
    LC_VAR   = 2'd0,
    LC_TWO   = 2'd1,
    LC_THREE = 2'd2,
    LC_BAD   = 2'd3
  } len_class_e;

  localparam logic [7:0] READ_CMD   = 8'h01;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
  localparam int         FILLER_LEN = 3;

  function automatic logic [7:0] filler_byte(input logic [1:0] idx);
    case (idx)
      2'd1:    filler_byte = 8'h07;
      default: filler_byte = 8'h02;
    endcase
  endfunction
endpackage

// File: rtl/i2cf_len_decode.sv
module i2cf_len_decode
  import i2cf_pkg::*;
(
  input  logic [7:0] hdr,
  input  logic [7:0] cnt,
  output logic [8:0] exp_len
);
  len_class_e cls;

  always_comb begin
    cls = len_class_e'(hdr[6:5]);
    if (!hdr[7] || cls == LC_VAR)
      exp_len = {1'b0, cnt} + 9'd2;
    else if (cls == LC_TWO)
      exp_len = 9'd2;
    else if (cls == LC_THREE)
      exp_len = 9'd3;
    else
      exp_len = '0;
  end
endmodule

// File: rtl/i2cf_tx_source.sv
module i2cf_tx_source
  import i2cf_pkg::*;
(
  input  logic       use_filler,
  input  logic [1:0] idx,
  input  logic [7:0] ext_byte,
  output logic [7:0] byte_o
);
  always_comb byte_o = use_filler ? filler_byte(idx) : ext_byte;
endmodule

// File: rtl/i2cf_req_ctl.sv
module i2cf_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic release_i,
  input  logic lower_i,
  output logic req_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)                req_n <= 1'b1;
    else if (release_i)        req_n <= 1'b1;
    else if (lower_i || kick)  req_n <= 1'b0;
  end

  // R12
  req_low_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past(kick || lower_i));
endmodule

// File: rtl/i2c_msg_framer.sv
module i2c_msg_framer
  import i2cf_pkg::*;
#(
  parameter int MSG_MAX = 32,
  parameter int PW      = $clog2(MSG_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_addr,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic          evt_irq,
  input  logic          evt_end,
  input  logic          evt_rcvd,
  input  logic          evt_rnw,
  input  logic [7:0]    evt_byte,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic          rx_slot_avail,
  output logic          rx_take,
  output logic          rx_wr_valid,
  output logic [PW-1:0] rx_wr_idx,
  output logic [7:0]    rx_wr_data,
  output logic          rx_done,
  output logic          rx_drop,
  output logic          xfer_done,
  input  logic          txq_nonempty,
  input  logic [PW-1:0] txq_len,
  output logic [PW-1:0] tx_rd_idx,
  input  logic [7:0]    tx_rd_data,
  output logic          tx_pop,
  input  logic          tx_kick,
  output logic          req_n,
  output logic          addr_mismatch,
  output logic          rx_overflow
);
  localparam logic [PW-1:0] MAX_POS = PW'(MSG_MAX);
  localparam logic [PW-1:0] FIL_LEN = PW'(FILLER_LEN);

  fr_state_e     state, st_n;
  logic [PW-1:0] pos, pos_n, len_q, len_n;
  logic [7:0]    b0, b0_n, b1, b1_n;
  logic          fil_q, fil_n;

  logic          acc, plain, rd_start, addr_start;
  logic [7:0]    snd, src_byte;
  logic [8:0]    exp_len;
  logic          take_c, drop_c, done_c, xfer_c, pop_c, mm_c, ovf_c, wr_c;
  logic [PW-1:0] wr_idx_c;
  logic          rel_c, low_c, src_fil;

  assign evt_ready = 1'b1;

  i2cf_len_decode u_len (
    .hdr     (b0),
    .cnt     (b1),
    .exp_len (exp_len)
  );

  assign tx_rd_idx = (state == ST_SEND) ? pos : '0;
  assign src_fil   = (state == ST_SEND) ? fil_q : !txq_nonempty;

  i2cf_tx_source u_src (
    .use_filler (src_fil),
    .idx        (tx_rd_idx[1:0]),
    .ext_byte   (tx_rd_data),
    .byte_o     (src_byte)
  );

  i2cf_req_ctl u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (tx_kick),
    .release_i (rel_c),
    .lower_i   (low_c),
    .req_n     (req_n)
  );

  always_comb begin
    st_n = state; pos_n = pos; len_n = len_q; b0_n = b0; b1_n = b1; fil_n = fil_q;
    snd = IDLE_BYTE;
    take_c = 1'b0; drop_c = 1'b0; done_c = 1'b0; xfer_c = 1'b0; pop_c = 1'b0;
    mm_c = 1'b0; ovf_c = 1'b0; wr_c = 1'b0; wr_idx_c = '0; rel_c = 1'b0; low_c = 1'b0;
    acc        = evt_valid && evt_irq;
    plain      = !evt_end && !evt_rcvd && !evt_rnw;
    rd_start   = evt_rnw && evt_rcvd && !evt_end;
    addr_start = evt_rcvd && !evt_rnw && !evt_end;
    if (acc) begin
      if (addr_start) begin
        st_n = ST_CMD;
        mm_c = (evt_byte != cfg_addr);
      end else begin
        case (state)
          ST_CMD: begin
            if (plain && rx_slot_avail) begin
              take_c = 1'b1; wr_c = 1'b1; wr_idx_c = '0;
              b0_n = evt_byte; pos_n = PW'(1); st_n = ST_FIRST;
            end else begin
              st_n = ST_IDLE;
            end
          end
          ST_FIRST: begin
            if (plain) begin
              wr_c = 1'b1; wr_idx_c = PW'(1);
              b1_n = evt_byte; pos_n = PW'(2); st_n = ST_RECV;
            end else if (rd_start && b0 == READ_CMD) begin
              drop_c = 1'b1;
              fil_n  = !txq_nonempty;
              len_n  = txq_nonempty ? txq_len : FIL_LEN;
              snd    = src_byte;
              pos_n  = PW'(1);
              rel_c  = 1'b1;
              st_n   = ST_SEND;
            end else begin
              st_n = ST_IDLE;
            end
          end
          ST_SEND: begin
            if (evt_end) begin
              if (pos == len_q) begin
                st_n  = ST_IDLE;
                pop_c = !fil_q;
              end else begin
                pos_n = '0;
                low_c = 1'b1;
              end
            end else if (!evt_rnw || evt_rcvd) begin
              st_n = ST_IDLE;
            end else if (pos < len_q) begin
              snd   = src_byte;
              pos_n = pos + PW'(1);
            end else begin
              st_n = ST_IDLE;
            end
          end
          ST_RECV: begin
            if (evt_end && !evt_rnw) begin
              if (int'(pos) != int'(exp_len)) begin
                drop_c = 1'b1;
              end else begin
                done_c = 1'b1;
                xfer_c = !b0[7];
              end
              st_n = ST_IDLE;
            end else if (evt_rnw || evt_rcvd) begin
              st_n = ST_IDLE;
            end else if (pos < MAX_POS) begin
              wr_c = 1'b1; wr_idx_c = pos;
              pos_n = pos + PW'(1);
            end else begin
              ovf_c = 1'b1;
            end
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; pos <= '0; len_q <= '0; b0 <= '0; b1 <= '0; fil_q <= 1'b0;
      tx_valid <= 1'b0; tx_byte <= IDLE_BYTE;
      rx_take <= 1'b0; rx_wr_valid <= 1'b0; rx_wr_idx <= '0; rx_wr_data <= '0;
      rx_done <= 1'b0; rx_drop <= 1'b0; xfer_done <= 1'b0; tx_pop <= 1'b0;
      addr_mismatch <= 1'b0; rx_overflow <= 1'b0;
    end else begin
      state <= st_n; pos <= pos_n; len_q <= len_n; b0 <= b0_n; b1 <= b1_n; fil_q <= fil_n;
      tx_valid      <= acc && evt_rnw && !evt_end;
      tx_byte       <= snd;
      rx_take       <= take_c;
      rx_wr_valid   <= wr_c;
      rx_wr_idx     <= wr_idx_c;
      rx_wr_data    <= evt_byte;
      rx_done       <= done_c;
      rx_drop       <= drop_c;
      xfer_done     <= xfer_c;
      tx_pop        <= pop_c;
      addr_mismatch <= mm_c;
      rx_overflow   <= ovf_c;
    end
  end

  // R13
  tx_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(evt_valid && evt_irq && evt_rnw && !evt_end));
  // R1
  spurious_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_irq) |=> (!tx_valid && !rx_wr_valid && !rx_take && !rx_done && !rx_drop));
  // R9
  close_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_drop));
  // R9
  xfer_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> rx_done);
  // R11
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_valid |-> (rx_wr_idx < MAX_POS));
  // R12
  release_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> tx_valid);
endmodule

// File: tb/i2c_msg_framer_tb.sv
module i2c_msg_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MSG_MAX = 32;
  localparam int PW = $clog2(MSG_MAX + 1);
  localparam logic [7:0] ADDR = 8'h8A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_addr = ADDR;
  logic evt_valid = 0, evt_irq = 0, evt_end = 0, evt_rcvd = 0, evt_rnw = 0;
  logic [7:0] evt_byte = 0;
  logic evt_ready, tx_valid, rx_take, rx_wr_valid, rx_done, rx_drop, xfer_done, tx_pop;
  logic [7:0] tx_byte, rx_wr_data, tx_rd_data;
  logic [PW-1:0] rx_wr_idx, tx_rd_idx;
  logic rx_slot_avail = 1, txq_nonempty = 1, tx_kick = 0;
  logic [PW-1:0] txq_len = 4;
  logic req_n, addr_mismatch, rx_overflow;
  logic [7:0] txmem [64];

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int m_st = 0, m_pos = 0, m_len = 0;
  int m_b0 = 0, m_b1 = 0;
  bit m_fil = 0;
  bit e_txv = 0, e_wr = 0, e_take = 0, e_drop = 0, e_done = 0, e_xfer = 0, e_pop = 0;
  bit e_mm = 0, e_ovf = 0, e_req = 1;
  int e_txb = 255, e_widx = 0, e_wdat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tx_rd_data = txmem[tx_rd_idx];

  i2c_msg_framer #(.MSG_MAX(MSG_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_irq(evt_irq), .evt_end(evt_end),
    .evt_rcvd(evt_rcvd), .evt_rnw(evt_rnw), .evt_byte(evt_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_slot_avail(rx_slot_avail), .rx_take(rx_take), .rx_wr_valid(rx_wr_valid),
    .rx_wr_idx(rx_wr_idx), .rx_wr_data(rx_wr_data), .rx_done(rx_done), .rx_drop(rx_drop),
    .xfer_done(xfer_done), .txq_nonempty(txq_nonempty), .txq_len(txq_len),
    .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data), .tx_pop(tx_pop), .tx_kick(tx_kick),
    .req_n(req_n), .addr_mismatch(addr_mismatch), .rx_overflow(rx_overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 evt_ready", int'(evt_ready), 1);
    chk("R13 tx_valid", int'(tx_valid), int'(e_txv));
    if (e_txv) chk("R13 tx_byte", int'(tx_byte), e_txb);
    chk("R4 rx_wr_valid", int'(rx_wr_valid), int'(e_wr));
    if (e_wr) begin
      chk("R4 rx_wr_idx", int'(rx_wr_idx), e_widx);
      chk("R4 rx_wr_data", int'(rx_wr_data), e_wdat);
    end
    chk("R3 rx_take", int'(rx_take), int'(e_take));
    chk("R9 rx_drop", int'(rx_drop), int'(e_drop));
    chk("R9 rx_done", int'(rx_done), int'(e_done));
    chk("R9 xfer_done", int'(xfer_done), int'(e_xfer));
    chk("R7 tx_pop", int'(tx_pop), int'(e_pop));
    chk("R2 addr_mismatch", int'(addr_mismatch), int'(e_mm));
    chk("R11 rx_overflow", int'(rx_overflow), int'(e_ovf));
    chk("R12 req_n", int'(req_n), int'(e_req));
  endtask

  function automatic int exp_len_of(int h, int c);
    int cls = (h >> 5) & 3;
    if (h < 128 || cls == 0) return c + 2;
    if (cls == 1) return 2;
    if (cls == 2) return 3;
    return -1;
  endfunction

  function automatic int tx_at(int p);
    if (m_fil) return (p == 1) ? 7 : 2;
    return int'(txmem[p]);
  endfunction

  task automatic model();
    int snd = 255;
    bit plain, rds;
    e_txv = 0; e_wr = 0; e_take = 0; e_drop = 0; e_done = 0; e_xfer = 0;
    e_pop = 0; e_mm = 0; e_ovf = 0;
    if (tx_kick) e_req = 0;
    if (!(evt_valid && evt_irq)) return;
    plain = !evt_end && !evt_rcvd && !evt_rnw;
    rds = evt_rnw && evt_rcvd && !evt_end;
    if (evt_rcvd && !evt_rnw && !evt_end) begin
      m_st = 1;
      e_mm = (evt_byte != cfg_addr);
    end else if (m_st == 1) begin
      if (plain && rx_slot_avail) begin
        e_take = 1; e_wr = 1; e_widx = 0; e_wdat = evt_byte;
        m_b0 = evt_byte; m_pos = 1; m_st = 2;
      end else m_st = 0;
    end else if (m_st == 2) begin
      if (plain) begin
        e_wr = 1; e_widx = 1; e_wdat = evt_byte;
        m_b1 = evt_byte; m_pos = 2; m_st = 4;
      end else if (rds && m_b0 == 1) begin
        e_drop = 1;
        m_fil = !txq_nonempty;
        m_len = m_fil ? 3 : int'(txq_len);
        snd = tx_at(0);
        m_pos = 1; e_req = 1; m_st = 3;
      end else m_st = 0;
    end else if (m_st == 3) begin
      if (evt_end) begin
        if (m_pos == m_len) begin m_st = 0; e_pop = !m_fil; end
        else begin m_pos = 0; e_req = 0; end
      end else if (!evt_rnw || evt_rcvd) m_st = 0;
      else if (m_pos < m_len) begin snd = tx_at(m_pos); m_pos++; end
      else m_st = 0;
    end else if (m_st == 4) begin
      if (evt_end && !evt_rnw) begin
        if (m_pos != exp_len_of(m_b0, m_b1)) e_drop = 1;
        else begin e_done = 1; e_xfer = (m_b0 < 128); end
        m_st = 0;
      end else if (evt_rnw || evt_rcvd) m_st = 0;
      else if (m_pos < MSG_MAX) begin
        e_wr = 1; e_widx = m_pos; e_wdat = evt_byte; m_pos++;
      end else e_ovf = 1;
    end
    if (evt_rnw && !evt_end) begin e_txv = 1; e_txb = snd; end
  endtask

  task automatic cyc(input bit v, input bit irq, input bit en, input bit rc, input bit rw,
                     input logic [7:0] b, input bit kick);
    @(negedge clk);
    compare();
    evt_valid = v; evt_irq = irq; evt_end = en; evt_rcvd = rc; evt_rnw = rw;
    evt_byte = b; tx_kick = kick;
    model();
  endtask

  task automatic ev(input bit en, input bit rc, input bit rw, input logic [7:0] b);
    cyc(1, 1, en, rc, rw, b, 0);
  endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 8'h00, 0); endtask
  task automatic addr(input logic [7:0] a); ev(0, 1, 0, a); endtask
  task automatic wb(input logic [7:0] b); ev(0, 0, 0, b); endtask
  task automatic rds(); ev(0, 1, 1, 8'h00); endtask
  task automatic rd(); ev(0, 0, 1, 8'h00); endtask
  task automatic fin(); ev(1, 0, 0, 8'h00); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) txmem[i] = 8'(8'h30 + i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state (R12 req_n high)
    idle();
    // R8 R9 R4 R3 non-event message, length c+2 = 5, xfer_done expected
    addr(ADDR); wb(8'h10); wb(8'h03); wb(8'hA1); wb(8'hA2); wb(8'hA3); fin(); idle();
    // R2 address mismatch still proceeds; R8 class 2 event, length 2, no xfer_done
    addr(8'h11); wb(8'hA3); wb(8'h55); fin(); idle();
    // R8 class 3 event length 3
    addr(ADDR); wb(8'hC2); wb(8'h09); wb(8'h0A); fin();
    // R8 variable event c+2
    addr(ADDR); wb(8'h83); wb(8'h01); wb(8'h77); fin();
    // R8 invalid class always dropped; R9 short message dropped
    addr(ADDR); wb(8'hE0); wb(8'h00); fin();
    addr(ADDR); wb(8'h20); wb(8'h04); wb(8'h01); fin();
    // R1 spurious events mid-receive leave state intact
    addr(ADDR); wb(8'h10); cyc(1, 0, 1, 1, 1, 8'h44, 0); wb(8'h01);
    cyc(1, 0, 0, 0, 0, 8'h45, 0); cyc(0, 1, 1, 0, 0, 8'h46, 0); wb(8'h02); wb(8'h03); fin();
    // R3 no slot available -> idle, later bytes ignored
    rx_slot_avail = 0; addr(ADDR); wb(8'h10); wb(8'h11); fin(); rx_slot_avail = 1;
    // R12 kick lowers request line; R5 legal read; R7 full send pops
    cyc(0, 0, 0, 0, 0, 8'h00, 1); idle();
    txq_len = 4;
    addr(ADDR); wb(8'h01); rds(); rd(); rd(); rd(); fin(); idle();
    // R5 illegal read after non-0x01 command
    addr(ADDR); wb(8'h05); rds(); rd(); idle();
    // R6 filler when queue empty
    txq_nonempty = 0;
    addr(ADDR); wb(8'h01); rds(); rd(); rd(); fin(); idle();
    txq_nonempty = 1;
    // R7 premature end restarts, then completes; R12 kick in read-start cycle loses
    txq_len = 3;
    addr(ADDR); wb(8'h01); cyc(1, 1, 0, 1, 1, 8'h00, 1); rd(); fin(); rd(); rd(); rd(); fin(); idle();
    // R7 overrun returns 0xFF and goes idle
    txq_len = 2;
    addr(ADDR); wb(8'h01); rds(); rd(); rd(); rd(); fin(); idle();
    // R10 unexpected flags in receive and command phases
    addr(ADDR); wb(8'h10); wb(8'h02); ev(0, 0, 1, 8'h00); wb(8'h99); fin();
    addr(ADDR); fin(); wb(8'h12); idle();
    addr(ADDR); wb(8'h10); ev(0, 1, 1, 8'h00); wb(8'h13); idle();
    // R11 overflow beyond MSG_MAX, then mismatch drop
    addr(ADDR); wb(8'h10); wb(8'd40);
    for (int i = 0; i < 40; i++) wb(8'(i));
    fin(); idle();
    // R13 read event while idle returns 0xFF
    rd(); idle(); idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule